// File: doc/BRIEF.md
# Bit-Sliced Pipelined Phase Accumulator

This block is the phase accumulator of a direct digital synthesizer. Every clock it adds a frequency control word to a running phase and presents the phase as a word that wraps modulo two to the power of its width. The carry chain is cut into slices of `SLICE_W` bits, with `NUM_SLICES` slices in all. Each slice registers its own sum and its carry out. The next slice up takes that carry one cycle later.

The control word is split into one segment per slice. Segment k passes through k delay registers before its adder. Slice k's sum then passes through `NUM_SLICES-1-k` further registers, so all segments of the output line up. The clock rate is that of a single `SLICE_W`-bit adder, and the output is exactly a plain accumulator's value delayed by `NUM_SLICES-1` cycles. A parameter selects a carry-lookahead adder inside each slice in place of ripple full adders.

Top module: `pacc_top`

## Requirements
- R1: Control word and phase are both `SLICE_W*NUM_SLICES` bits wide. The default is one-bit slices and eight slices, giving 8 bits. Slice k owns bits `[k*SLICE_W +: SLICE_W]`.
- R2: Let A(e) be the wrapped sum of the control words sampled at rising edges 1..e after reset release. After edge e the phase output equals A(e-(NUM_SLICES-1)), and zero when that index is below 1.
- R3: From reset with a control word of 1 held, the phase first becomes nonzero after the NUM_SLICES-th rising edge. That is edge 8 for 1x8 slicing, edge 2 for 4x2 slicing and edge 1 for 8x1 slicing.
- R4: An active-low asynchronous reset clears every sum, carry and delay register at once. The phase reads zero while reset is low, with no clock edge needed.
- R5: The carry out of the top slice is dropped, so the phase wraps modulo 2^(SLICE_W*NUM_SLICES). For example, 0x80 added twice to 0x00 gives 0x00, and adding 0xFF decrements the phase.
- R6: A slice's registered carry is set only when its new sum is not larger than its old sum, and clear only when its new sum is not smaller.
- R7: A control word that changes every cycle still yields the R2 result, because each segment reaches its adder k cycles late (segment 1 one cycle late).
- R8: With `USE_CLA` set and `SLICE_W` a multiple of 4, each slice adds with 4-bit lookahead groups (generate = a AND b, propagate = a XOR b) and gives the same phase as the ripple variant.
- R9: Once the control word has been zero for `NUM_SLICES` consecutive samples, the phase holds steady at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fcw | input | SLICE_W*NUM_SLICES | Frequency control word, sampled every edge |
| phase | output | SLICE_W*NUM_SLICES | Aligned accumulated phase |

## Verification
The assertions take for granted that the control word is stable around each rising edge. They also assume reset is released away from an edge, since their past-value checks skip the first edge after release. The stimulus drives the control word and reset only on falling edges, and the mid-run reset is applied between edges, so both assumptions hold.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  // one-bit full adder: {carry, sum}
  function automatic logic [1:0] fa_bit(input logic a, input logic b, input logic c);
    logic s, co;
    s  = a ^ b ^ c;
    co = (a & b) | (b & c) | (c & a);
    return {co, s};
  endfunction

  // 4-bit carry-lookahead group: {carry_out, sum[3:0]}
  function automatic logic [4:0] cla_add4(input logic [3:0] a, input logic [3:0] b, input logic c0);
    logic [3:0] g, p;
    logic [4:0] c;
    g = a & b;
    p = a ^ b;
    c[0] = c0;
    c[1] = g[0] | (p[0] & c0);
    c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c0);
    c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c0);
    c[4] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0])
         | (p[3] & p[2] & p[1] & p[0] & c0);
    return {c[4], p ^ c[3:0]};
  endfunction

endpackage

// File: rtl/pacc_dly.sv
module pacc_dly #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stage [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
          stage[0] <= d;
          for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
      end
      assign q = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/pacc_slice.sv
module pacc_slice
  import pacc_pkg::*;
#(
  parameter int unsigned N       = 1,
  parameter bit          USE_CLA = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] addend,
  input  logic         cin,
  output logic [N-1:0] sum_q,
  output logic         cout_q
);
  logic [N-1:0] sum_d;
  logic         cout_d;

  generate
    if (USE_CLA && (N % 4 == 0)) begin : g_cla
      localparam int unsigned GROUPS = N / 4;
      logic [GROUPS:0] gcarry;
      assign gcarry[0] = cin;
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [4:0] res;
        assign res            = cla_add4(sum_q[g*4 +: 4], addend[g*4 +: 4], gcarry[g]);
        assign sum_d[g*4 +: 4] = res[3:0];
        assign gcarry[g+1]    = res[4];
      end
      assign cout_d = gcarry[GROUPS];
    end else begin : g_rca
      logic [N:0] rc;
      assign rc[0] = cin;
      for (genvar i = 0; i < N; i++) begin : g_bit
        logic [1:0] res;
        assign res      = fa_bit(sum_q[i], addend[i], rc[i]);
        assign sum_d[i] = res[0];
        assign rc[i+1]  = res[1];
      end
      assign cout_d = rc[N];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      cout_q <= cout_d;
    end
  end
endmodule

// File: rtl/pacc_top.sv
module pacc_top #(
  parameter int unsigned SLICE_W    = 1,
  parameter int unsigned NUM_SLICES = 8,
  parameter bit          USE_CLA    = 1'b0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [SLICE_W*NUM_SLICES-1:0]   fcw,
  output logic [SLICE_W*NUM_SLICES-1:0]   phase
);
  localparam int unsigned W = SLICE_W * NUM_SLICES;

  // named internal events, watched by the bound checker
  logic [W-1:0]          skew_fcw;
  logic [W-1:0]          slice_sum;
  logic [NUM_SLICES-1:0] slice_carry;
  logic [NUM_SLICES-1:0] slice_cin;

  assign slice_cin[0] = 1'b0;

  generate
    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
      if (k > 0) begin : g_chain
        assign slice_cin[k] = slice_carry[k-1];
      end

      pacc_dly #(.W(SLICE_W), .DEPTH(k)) u_skew (
        .clk(clk), .rst_n(rst_n),
        .d(fcw[k*SLICE_W +: SLICE_W]),
        .q(skew_fcw[k*SLICE_W +: SLICE_W])
      );

      pacc_slice #(.N(SLICE_W), .USE_CLA(USE_CLA)) u_add (
        .clk(clk), .rst_n(rst_n),
        .addend(skew_fcw[k*SLICE_W +: SLICE_W]),
        .cin(slice_cin[k]),
        .sum_q(slice_sum[k*SLICE_W +: SLICE_W]),
        .cout_q(slice_carry[k])
      );

      pacc_dly #(.W(SLICE_W), .DEPTH(NUM_SLICES-1-k)) u_deskew (
        .clk(clk), .rst_n(rst_n),
        .d(slice_sum[k*SLICE_W +: SLICE_W]),
        .q(phase[k*SLICE_W +: SLICE_W])
      );
    end
  endgenerate
endmodule

// File: rtl/pacc_chk.sv
module pacc_chk #(
  parameter int unsigned N = 1,
  parameter int unsigned M = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N*M-1:0] fcw,
  input logic [N*M-1:0] phase,
  input logic [N*M-1:0] skew_fcw,
  input logic [N*M-1:0] slice_sum,
  input logic [M-1:0]   slice_carry
);
  localparam int unsigned ZW = $clog2(M + 1) + 1;
  logic [ZW-1:0] zrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zrun <= '0;
    else if (fcw != '0) zrun <= '0;
    else if (zrun < ZW'(M)) zrun <= zrun + 1'b1;
  end

  // R4: phase cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) p_reset_clear_r4: assert (phase == '0);
  end

  // R2: lowest slice advances by its unskewed segment each cycle
  p_low_slice_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> slice_sum[N-1:0] == N'($past(slice_sum[N-1:0]) + $past(fcw[N-1:0])));

  // R9: phase holds after a long run of zero control words
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fcw == '0 && zrun == ZW'(M)) |=> $stable(phase));

  generate
    for (genvar k = 0; k < M; k++) begin : g_k
      // R6: carry set means the slice sum did not grow
      p_carry_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && slice_carry[k]) |-> slice_sum[k*N +: N] <= $past(slice_sum[k*N +: N]));
      // R6: carry clear means the slice sum did not shrink
      p_carry_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !slice_carry[k]) |-> slice_sum[k*N +: N] >= $past(slice_sum[k*N +: N]));
    end
    if (M >= 2) begin : g_skew
      // R7: segment 1 reaches its adder one cycle late
      p_skew_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> skew_fcw[N +: N] == $past(fcw[N +: N]));
    end
  endgenerate
endmodule

bind pacc_top pacc_chk #(.N(SLICE_W), .M(NUM_SLICES)) u_chk (
  .clk(clk), .rst_n(rst_n), .fcw(fcw), .phase(phase),
  .skew_fcw(skew_fcw), .slice_sum(slice_sum), .slice_carry(slice_carry)
);

// File: tb/sim_pacc_top.sv
module sim_pacc_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] fcw;
  logic [7:0] ph0, ph1, ph2;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model: acc_m is the plain accumulator, hist[d] its value d edges ago
  logic [7:0] acc_m;
  logic [7:0] hist [0:7];

  always #10 clk = ~clk;

  pacc_top u0 (.clk(clk), .rst_n(rst_n), .fcw(fcw), .phase(ph0));
  pacc_top #(.SLICE_W(4), .NUM_SLICES(2), .USE_CLA(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .fcw(fcw), .phase(ph1));
  pacc_top #(.SLICE_W(8), .NUM_SLICES(1)) u2 (.clk(clk), .rst_n(rst_n), .fcw(fcw), .phase(ph2));

  // stimulus: {fcw, repeat count}
  localparam logic [15:0] VEC [0:9] = '{
    16'h01_05, 16'h80_04, 16'hFF_06, 16'h00_09, 16'h37_0C,
    16'hC9_07, 16'h00_0A, 16'h7F_05, 16'h01_03, 16'hFE_08 };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    acc_m = '0;
    for (int i = 0; i < 8; i++) hist[i] = '0;
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input logic [7:0] f, input string tag);
    fcw = f;
    @(posedge clk);
    acc_m = acc_m + f;
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = acc_m;
    @(negedge clk);
    chk(ph0, hist[7], tag, "1x8 phase");
    chk(ph1, hist[1], "R8", "4x2 lookahead phase");
    chk(ph2, hist[0], tag, "8x1 phase");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fcw   = 8'h5A;
    model_clear();
    repeat (3) @(negedge clk);
    // R4 / R1: reset state and widths
    chk(ph0, 8'h00, "R4", "reset 1x8");
    chk(ph1, 8'h00, "R4", "reset 4x2");
    chk(ph2, 8'h00, "R4", "reset 8x1");
    chk(8'($bits(ph0)), 8'd8, "R1", "phase width");
    rst_n = 1'b1;

    // R3: first nonzero edge per slicing
    begin
      int first0 = 0, first1 = 0, first2 = 0;
      for (int n = 1; n <= 10; n++) begin
        step(8'h01, "R3");
        if (first0 == 0 && ph0 != 0) first0 = n;
        if (first1 == 0 && ph1 != 0) first1 = n;
        if (first2 == 0 && ph2 != 0) first2 = n;
      end
      chk(8'(first0), 8'd8, "R3", "first nonzero edge 1x8");
      chk(8'(first1), 8'd2, "R3", "first nonzero edge 4x2");
      chk(8'(first2), 8'd1, "R3", "first nonzero edge 8x1");
    end

    // table walk: R2 main function, R5 wrap codes, R9 zero holds
    for (int v = 0; v < 10; v++) begin
      for (int r = 0; r < int'(VEC[v][7:0]); r++) begin
        if (VEC[v][15:8] == 8'h80 || VEC[v][15:8] == 8'hFF) step(VEC[v][15:8], "R5");
        else if (VEC[v][15:8] == 8'h00) step(VEC[v][15:8], "R9");
        else step(VEC[v][15:8], "R2");
      end
    end

    // R7: control word changing every cycle
    for (int i = 0; i < 20; i++) step((i % 2 == 1) ? 8'hA5 : 8'h3C + 8'(i), "R7");

    // R4: asynchronous reset mid-run, checked before any edge
    #5 rst_n = 1'b0;
    #1;
    chk(ph0, 8'h00, "R4", "async clear 1x8");
    chk(ph1, 8'h00, "R4", "async clear 4x2");
    chk(ph2, 8'h00, "R4", "async clear 8x1");
    model_clear();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) step(8'hF0, "R5");
    for (int i = 0; i < 10; i++) step(8'h00, "R9");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule